// File: doc/BRIEF.md
# SPI Opcode-Framed NAND Bridge

This block is an SPI mode-0 slave that sits between a host serial port and a parallel NAND-side byte port. Each chip-select frame starts with a one-byte opcode. The opcode selects a fixed frame shape. One shape loads an 8-bit output register. Two shapes switch a separate LED line. One streams write bytes to the NAND port. Two return NAND read bytes on MISO: a plain read and an addressed fast read. Any byte that follows a payload-free opcode or an unknown opcode is ignored.

The SPI pins are oversampled in the system clock domain, so sclk must be several times slower than clk. Read bytes are fetched one byte ahead, which puts each byte's MSB on MISO before the first rising sclk edge of that byte. Writes are held back by one byte, so the trailing idle byte the host sends at the end of a write frame never reaches the NAND port.

Top module: `spi_nand_bridge`

## Requirements
- R1: SPI runs in mode 0. MOSI is sampled on rising sclk, MSB first. MISO changes only after falling sclk edges inside a byte, and each returned byte's MSB is valid before that byte's first rising edge.
- R2: After reset: cfg_out = 0x1F, led5_n = 1, no NAND request is active, and miso = 0. In cfg_out, bits 0..3 are the active-low LED lines, bit 4 is the active-low chip enable, and bits 5..7 are general outputs.
- R3: Opcode 0x09 loads the next byte of the frame into cfg_out. Any later bytes in that frame leave cfg_out unchanged.
- R4: Opcode 0x0C drives led5_n low and opcode 0x0D drives it high. Neither changes cfg_out.
- R5: After opcode 0x08, every byte except the last byte of the frame is issued in order as a NAND write. The last byte is never issued.
- R6: After opcode 0x0A, the next byte is an idle byte and returns 0. Each later byte returns the next NAND read byte.
- R7: Opcode 0x0B is followed by a 24-bit address, high byte first, and then a dummy byte. Both return 0. Each later byte returns the NAND byte read at nand_addr, and nand_addr starts at the sent address and steps by one per read.
- R8: An unknown opcode causes no NAND request and no output change, and MISO stays 0 for the rest of the frame.
- R9: Raising cs_n ends the frame. Partial bits and a held write byte are discarded, and the next frame decodes a new opcode.
- R10: A NAND request holds, with stable write data and address, until nand_ack. A read and a write are never requested together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | SPI serial clock (idle low) |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data from host |
| miso | output | 1 | SPI data to host |
| cfg_out | output | 8 | Configuration/output register |
| led5_n | output | 1 | Separate active-low LED line |
| nand_rd_req | output | 1 | Read request, held until ack |
| nand_wr_req | output | 1 | Write request, held until ack |
| nand_wdata | output | 8 | Write data byte |
| nand_addr | output | 24 | Fast-read address |
| nand_rdata | input | 8 | Read data, taken on ack |
| nand_ack | input | 1 | Completes the pending request |

## Verification
At each byte boundary of a read stream, one cycle does two things: it loads the prefetched byte into the MISO shifter and it issues the next fetch. At each boundary of a write stream, one cycle does two things: it issues the held byte and it captures the new one. Back-to-back read frames and write frames provoke both coincidences. In the write frames, a scoreboard queue compares the order and content of the bytes forwarded to the NAND port. In the read frames, the data shifted out is compared with a sequential source and with an address-keyed source, and a wrong address step shows up as a wrong byte.

// File: rtl/spi_nb_pkg.sv
// Package: opcodes, frame phases and shared widths for the SPI NAND bridge.
package spi_nb_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OPC_WRITE  = 8'h08;
    localparam logic [BYTE_W-1:0] OPC_CFG    = 8'h09;
    localparam logic [BYTE_W-1:0] OPC_READ   = 8'h0A;
    localparam logic [BYTE_W-1:0] OPC_FAST   = 8'h0B;
    localparam logic [BYTE_W-1:0] OPC_LED_ON = 8'h0C;
    localparam logic [BYTE_W-1:0] OPC_LED_OF = 8'h0D;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_CFG,
        PH_WR,
        PH_RD_IDLE,
        PH_FA_ADDR,
        PH_FA_DUMMY,
        PH_RD_DATA,
        PH_SKIP
    } phase_t;
endpackage

// File: rtl/spi_nb_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes each bit is a slow level signal; no bundle coherency is implied.
module spi_nb_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the raw inputs through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_nb_shifter.sv
// Module: mode-0 SPI bit engine working on synchronized pins.
// Detects sclk edges, assembles received bytes MSB first and shifts the
// transmit byte out after falling edges. A load at a byte boundary is held
// over the boundary falling edge, so the MSB stays on MISO for the first rise.
module spi_nb_shifter
    import spi_nb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_q,
    input  logic              cs_n_q,
    input  logic              mosi_q,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic              sclk_d;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              rise;
    logic              fall;

    // Edge detection, gated by an active frame.
    assign rise = sclk_q & ~sclk_d & ~cs_n_q;
    assign fall = ~sclk_q & sclk_d & ~cs_n_q;

    // Byte completion and the assembled byte including the current bit.
    assign byte_done = rise && (bit_cnt == CNT_W'(BYTE_W - 1));
    assign rx_byte   = {rx_sh[BYTE_W-2:0], mosi_q};
    assign miso      = tx_sh[BYTE_W-1];

    // Remember last sclk level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_q;
    end

    // Receive shift and bit counter; cleared whenever the frame is closed.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_q) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
        end else if (rise) begin
            rx_sh   <= rx_byte;
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Transmit shift: load at boundary, shift after falling edges inside a byte.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_q) begin
            tx_sh <= '0;
        end else if (tx_load) begin
            tx_sh <= tx_byte;
        end else if (fall && bit_cnt != '0) begin
            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
    end

    // R9: a closed frame drives MISO low on the next cycle.
    a_r9_idle_miso_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_q |=> !miso);

    // R1: the falling edge at a byte boundary never shifts the fresh MSB away.
    a_r1_boundary_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && bit_cnt == '0 && !tx_load) |=> $stable(tx_sh));
endmodule

// File: rtl/spi_nb_seq.sv
// Module: frame sequencer. Decodes the opcode byte and walks the frame
// phases. Owns the output register, the separate LED flop and the NAND
// request handshake. Reads are fetched one byte ahead; writes are held one
// byte behind so that the trailing idle byte is dropped.
// Assumes ADDR_W is a multiple of 8 and at least 16.
module spi_nb_seq
    import spi_nb_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter logic [BYTE_W-1:0] CFG_RST = 8'h1F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_act,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              tx_load,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] cfg_q,
    output logic              led5_n,
    output logic              rd_req,
    output logic              wr_req,
    output logic [BYTE_W-1:0] wdata,
    output logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] rdata,
    input  logic              ack
);
    localparam int ADDR_BYTES = ADDR_W / BYTE_W;
    localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    phase_t            phase;
    logic [IDX_W-1:0]  addr_idx;
    logic              fa_mode;
    logic [BYTE_W-1:0] wr_pend;
    logic              wr_pend_v;
    logic [BYTE_W-1:0] rd_buf;
    logic              step;
    logic              fetch_go;
    logic              wr_go;
    logic              addr_load;
    logic              cfg_load;
    logic              led_on_go;
    logic              led_off_go;

    // Per-byte decode strobes for this cycle.
    always_comb begin
        step       = byte_done && frame_act;
        tx_load    = step && (phase == PH_RD_IDLE || phase == PH_FA_DUMMY ||
                              phase == PH_RD_DATA);
        tx_byte    = rd_buf;
        fetch_go   = tx_load ||
                     (step && phase == PH_OPC && rx_byte == OPC_READ) ||
                     (step && phase == PH_FA_ADDR &&
                      addr_idx == IDX_W'(ADDR_BYTES - 1));
        wr_go      = step && phase == PH_WR && wr_pend_v;
        addr_load  = step && phase == PH_FA_ADDR;
        cfg_load   = step && phase == PH_CFG;
        led_on_go  = step && phase == PH_OPC && rx_byte == OPC_LED_ON;
        led_off_go = step && phase == PH_OPC && rx_byte == OPC_LED_OF;
    end

    // Frame phase walk, reset to opcode decode whenever chip select is high.
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_act) begin
            phase     <= PH_OPC;
            addr_idx  <= '0;
            wr_pend_v <= 1'b0;
            wr_pend   <= '0;
            if (!rst_n) fa_mode <= 1'b0;
        end else if (step) begin
            case (phase)
                PH_OPC: begin
                    fa_mode <= (rx_byte == OPC_FAST);
                    case (rx_byte)
                        OPC_CFG:   phase <= PH_CFG;
                        OPC_WRITE: phase <= PH_WR;
                        OPC_READ:  phase <= PH_RD_IDLE;
                        OPC_FAST:  phase <= PH_FA_ADDR;
                        default:   phase <= PH_SKIP;
                    endcase
                end
                PH_CFG:      phase <= PH_SKIP;
                PH_WR: begin
                    wr_pend   <= rx_byte;
                    wr_pend_v <= 1'b1;
                end
                PH_RD_IDLE:  phase <= PH_RD_DATA;
                PH_FA_ADDR: begin
                    addr_idx <= addr_idx + 1'b1;
                    if (addr_idx == IDX_W'(ADDR_BYTES - 1)) phase <= PH_FA_DUMMY;
                end
                PH_FA_DUMMY: phase <= PH_RD_DATA;
                default:     phase <= phase;
            endcase
        end
    end

    // Output register and separate LED flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= CFG_RST;
            led5_n <= 1'b1;
        end else begin
            if (cfg_load)   cfg_q  <= rx_byte;
            if (led_on_go)  led5_n <= 1'b0;
            if (led_off_go) led5_n <= 1'b1;
        end
    end

    // NAND handshake: requests held until ack, address loaded and stepped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_req <= 1'b0;
            wr_req <= 1'b0;
            wdata  <= '0;
            rd_buf <= '0;
            addr   <= '0;
        end else begin
            if (rd_req && ack) begin
                rd_req <= 1'b0;
                rd_buf <= rdata;
                if (fa_mode) addr <= addr + 1'b1;
            end
            if (wr_req && ack) wr_req <= 1'b0;
            if (addr_load) addr <= {addr[ADDR_W-BYTE_W-1:0], rx_byte};
            if (fetch_go) rd_req <= 1'b1;
            if (wr_go) begin
                wr_req <= 1'b1;
                wdata  <= wr_pend;
            end
        end
    end

    // R10: a write request holds its data until acknowledged.
    a_r10_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !ack) |=> (wr_req && $stable(wdata)));

    // R10: a read request holds its address until acknowledged.
    a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !ack && !addr_load) |=> (rd_req && $stable(addr)));

    // R10: read and write never requested together.
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));

    // R3: the output register moves only after a config payload byte.
    a_r3_cfg_source: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_q) |-> $past(cfg_load));

    // R4: the LED flop moves only after an LED opcode.
    a_r4_led_source: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(led5_n) |-> $past(led_on_go || led_off_go));

    // R7: each completed fast read steps the address by one.
    a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && ack && fa_mode && !addr_load) |=> (addr == $past(addr) + 1'b1));
endmodule

// File: rtl/spi_nand_bridge.sv
// Module: top of the SPI opcode-framed NAND bridge.
// Synchronizes the SPI pins into clk, runs the bit engine and the frame
// sequencer. Assumes sclk half period spans at least four clk cycles.
module spi_nand_bridge
    import spi_nb_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int SYNC_STAGES = 2,
    parameter logic [7:0] CFG_RST = 8'h1F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    output logic [7:0]        cfg_out,
    output logic              led5_n,
    output logic              nand_rd_req,
    output logic              nand_wr_req,
    output logic [7:0]        nand_wdata,
    output logic [ADDR_W-1:0] nand_addr,
    input  logic [7:0]        nand_rdata,
    input  logic              nand_ack
);
    logic [2:0]        pins_q;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic              tx_load;
    logic [BYTE_W-1:0] tx_byte;

    spi_nb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk, cs_n, mosi}),
        .q     (pins_q)
    );

    spi_nb_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_q    (pins_q[2]),
        .cs_n_q    (pins_q[1]),
        .mosi_q    (pins_q[0]),
        .tx_load   (tx_load),
        .tx_byte   (tx_byte),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .miso      (miso)
    );

    spi_nb_seq #(.ADDR_W(ADDR_W), .CFG_RST(CFG_RST)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_act (~pins_q[1]),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .tx_load   (tx_load),
        .tx_byte   (tx_byte),
        .cfg_q     (cfg_out),
        .led5_n    (led5_n),
        .rd_req    (nand_rd_req),
        .wr_req    (nand_wr_req),
        .wdata     (nand_wdata),
        .addr      (nand_addr),
        .rdata     (nand_rdata),
        .ack       (nand_ack)
    );
endmodule

// File: tb/spi_nand_bridge_tb_top.sv
// Bench: SPI host driver, behavioural NAND byte source/sink, write scoreboard.
module spi_nand_bridge_tb_top;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [7:0]  cfg_out;
    logic        led5_n;
    logic        nand_rd_req;
    logic        nand_wr_req;
    logic [7:0]  nand_wdata;
    logic [23:0] nand_addr;
    logic [7:0]  nand_rdata;
    logic        nand_ack;

    int   n_chk = 0;
    int   n_bad = 0;
    int   seq_cnt = 0;
    bit   fast_src = 1'b0;
    bit   done = 1'b0;
    logic [7:0] exp_wr[$];

    always #10 clk = ~clk;

    spi_nand_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .cfg_out(cfg_out), .led5_n(led5_n),
        .nand_rd_req(nand_rd_req), .nand_wr_req(nand_wr_req),
        .nand_wdata(nand_wdata), .nand_addr(nand_addr),
        .nand_rdata(nand_rdata), .nand_ack(nand_ack)
    );

    function automatic logic [7:0] seq_val(input int n);
        return 8'(8'h3C + n * 7);
    endfunction

    function automatic logic [7:0] addr_val(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // NAND model: ack one cycle after a request, data from counter or address.
    always @(posedge clk) begin
        if (!rst_n) begin
            nand_ack   <= 1'b0;
            nand_rdata <= 8'h00;
        end else if (nand_ack) begin
            nand_ack <= 1'b0;
        end else if (nand_rd_req || nand_wr_req) begin
            nand_ack <= 1'b1;
            if (nand_rd_req) begin
                if (fast_src) nand_rdata <= addr_val(nand_addr);
                else begin
                    nand_rdata <= seq_val(seq_cnt);
                    seq_cnt    <= seq_cnt + 1;
                end
            end
        end
    end

    // Scoreboard monitor: every completed write pops the expected queue.
    always @(posedge clk) begin
        if (rst_n && nand_ack) begin
            chk(!(nand_rd_req && nand_wr_req), "R10 exclusive requests",
                {nand_rd_req, nand_wr_req}, 0);
            if (nand_wr_req) begin
                if (exp_wr.size() == 0) chk(1'b0, "R5 unexpected write", nand_wdata, 0);
                else begin
                    logic [7:0] e;
                    e = exp_wr.pop_front();
                    chk(nand_wdata == e, "R5 write data order", nand_wdata, e);
                end
            end
        end
    end

    task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nb; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        spi_bits(tx, 8, rx);
    endtask

    task automatic open_frame();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic close_frame();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        int s0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 reset state
        chk(cfg_out == 8'h1F, "R2 cfg reset", cfg_out, 8'h1F);
        chk(led5_n == 1'b1, "R2 led reset", led5_n, 1);
        chk(!nand_rd_req && !nand_wr_req, "R2 no request", {nand_rd_req, nand_wr_req}, 0);
        chk(miso == 1'b0, "R2 miso low", miso, 0);

        // R3 config load, extra byte ignored
        open_frame();
        spi_byte(8'h09, r);
        spi_byte(8'hA5, r);
        spi_byte(8'h00, r);
        close_frame();
        chk(cfg_out == 8'hA5, "R3 config load", cfg_out, 8'hA5);

        // R4 LED on / off, config untouched
        open_frame(); spi_byte(8'h0C, r); close_frame();
        chk(led5_n == 1'b0, "R4 led on", led5_n, 0);
        chk(cfg_out == 8'hA5, "R4 cfg kept", cfg_out, 8'hA5);
        open_frame(); spi_byte(8'h0D, r); spi_byte(8'h0C, r); close_frame();
        chk(led5_n == 1'b1, "R4 led off", led5_n, 1);

        // R5 write stream with trailing idle byte
        exp_wr.push_back(8'h11); exp_wr.push_back(8'h22); exp_wr.push_back(8'h33);
        open_frame();
        spi_byte(8'h08, r);
        spi_byte(8'h11, r); spi_byte(8'h22, r); spi_byte(8'h33, r);
        spi_byte(8'hFF, r);
        close_frame();
        chk(exp_wr.size() == 0, "R5 all writes seen", exp_wr.size(), 0);
        // R5 write frame carrying only the idle byte
        open_frame(); spi_byte(8'h08, r); spi_byte(8'h77, r); close_frame();

        // R6 plain read
        fast_src = 1'b0;
        s0 = seq_cnt;
        open_frame();
        spi_byte(8'h0A, r);
        chk(r == 8'h00, "R6 opcode byte miso", r, 0);
        spi_byte(8'h00, r);
        chk(r == 8'h00, "R6 idle byte miso", r, 0);
        for (int j = 0; j < 4; j++) begin
            spi_byte(8'h00, r);
            chk(r == seq_val(s0 + j), "R6 R1 read data", r, seq_val(s0 + j));
        end
        close_frame();

        // R7 fast read crossing a byte carry
        fast_src = 1'b1;
        open_frame();
        spi_byte(8'h0B, r);
        spi_byte(8'h12, r); chk(r == 8'h00, "R7 addr byte miso", r, 0);
        spi_byte(8'h34, r);
        spi_byte(8'hFE, r);
        spi_byte(8'h00, r); chk(r == 8'h00, "R7 dummy byte miso", r, 0);
        for (int j = 0; j < 4; j++) begin
            logic [7:0] e;
            e = addr_val(24'h1234FE + 24'(j));
            spi_byte(8'h00, r);
            chk(r == e, "R7 R1 fast data", r, e);
        end
        close_frame();
        fast_src = 1'b0;

        // R8 unknown opcode
        open_frame();
        spi_byte(8'h55, r);
        spi_byte(8'h09, r); chk(r == 8'h00, "R8 miso low", r, 0);
        spi_byte(8'h42, r); chk(r == 8'h00, "R8 miso low", r, 0);
        close_frame();
        chk(cfg_out == 8'hA5 && led5_n == 1'b1, "R8 outputs kept", {cfg_out, led5_n}, {8'hA5, 1'b1});

        // R9 abort: partial opcode, then a fresh config frame
        open_frame(); spi_bits(8'hF0, 4, r); close_frame();
        open_frame(); spi_byte(8'h09, r); spi_byte(8'h3C, r); close_frame();
        chk(cfg_out == 8'h3C, "R9 fresh decode", cfg_out, 8'h3C);
        // R9 abort mid-write: held byte is dropped
        open_frame();
        spi_byte(8'h08, r); spi_byte(8'h44, r); spi_bits(8'h99, 4, r);
        close_frame();
        repeat (20) @(negedge clk);
        chk(exp_wr.size() == 0 && !nand_wr_req, "R9 R5 held byte dropped", nand_wr_req, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule